// File: doc/BRIEF.md
# Index Prefix Decoder

This block is a small decode stage placed in front of the main opcode decoder of an 8-bit processor. It accepts a stream of instruction bytes, one per cycle when the valid strobe is high, and follows the prefix bytes that come before the opcode. The four prefix bytes are 0xDD (switch to the first index register), 0xFD (switch to the second index register), 0xCB (bit/shift table) and 0xED (extended table). It reports one decoded instruction per completion strobe. That report contains the final opcode, the table that opcode belongs to, and a selector saying which 16-bit pointer stands in for HL. It also gives two flags that turn H and L references into the high and low halves of the index register, a displacement flag with the signed displacement byte, and a flag that tells the executer to write the result of an indexed bit/shift operation back into the register named by the opcode.

Prefixes can be chained. A later prefix replaces an earlier one, so only the last index prefix counts, and 0xED cancels any index prefix. When the opcode addresses memory through HL under an index prefix, the displacement byte follows the opcode, and the stage holds the instruction until that byte arrives. In the indexed bit/shift form the displacement comes before the final opcode. Immediate operand bytes and execution belong to later stages.

Top module: `idx_prefix_decoder`

## Requirements
- R1: After reset, `instrDone` is low and every decoded output is zero. The pointer code 0 means HL, 1 means IX and 2 means IY. The table code 0 means main, 1 means bit/shift (0xCB) and 2 means extended (0xED).
- R2: A byte that is not a prefix and is accepted with no prefix pending completes at once. In the cycle after acceptance, `instrDone` is high, `opcode` equals the byte, and the pointer is 0 and the table is 0. `useHi`, `useLo`, `dispValid` and `copyToReg` are all low.
- R3: After 0xDD the main-table opcode reports pointer 1, and after 0xFD it reports pointer 2.
- R4: In a run of index prefixes only the last one selects the pointer. An index prefix followed by 0xED is dropped, so the opcode after 0xED reports pointer 0 and table 2.
- R5: Under an index prefix, a main opcode that does not address memory raises `useHi` when it names H and `useLo` when it names L. The opcodes that name H are 0x24 to 0x26, any 0x40 to 0x7F with bits 5:3 equal to 4, and any 0x40 to 0xBF with bits 2:0 equal to 4. The opcodes that name L are 0x2C to 0x2E and the same fields with the value 5.
- R6: Under an index prefix, a main opcode that addresses memory is completed by the byte after it, and that byte is the displacement. The memory opcodes are 0x34 to 0x36; 0x40 to 0x7F other than 0x76 with bits 5:3 or bits 2:0 equal to 6; and 0x80 to 0xBF with bits 2:0 equal to 6. The report carries `dispValid` high, the displacement, and the index pointer. `useHi` and `useLo` are low, because H and L keep their plain meaning in such an instruction.
- R7: The sequence index prefix, 0xCB, displacement, opcode completes on the opcode byte. The report has table 1, the index pointer, `dispValid` high and the displacement. `instrDone` stays low after the 0xCB byte and after the displacement byte.
- R8: In the indexed bit/shift form, `copyToReg` is high exactly when bits 2:0 of the opcode are not 6.
- R9: The exchange opcodes 0xEB and 0xD9 report pointer 0 even after an index prefix.
- R10: A cycle with `byteValid` low changes no prefix state and gives no completion.
- R11: A 0xCB or 0xED with no index prefix makes the next byte final, reported with table 1 or 2 and pointer 0.
- R12: `instrDone` is high for one cycle per completed instruction, and the decoded outputs hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | The byte on `byteIn` is accepted this cycle |
| byteIn | input | 8 | Instruction stream byte |
| instrDone | output | 1 | One-cycle strobe: a decoded instruction is on the outputs |
| opcode | output | 8 | Final opcode byte |
| ptrSel | output | 2 | Pointer replacing HL: 0 HL, 1 IX, 2 IY |
| tableSel | output | 2 | Opcode table: 0 main, 1 bit/shift, 2 extended |
| useHi | output | 1 | H references go to the high half of the index register |
| useLo | output | 1 | L references go to the low half of the index register |
| dispValid | output | 1 | A displacement belongs to this instruction |
| disp | output | 8 | Signed displacement byte |
| copyToReg | output | 1 | Indexed bit/shift result is also written to the named register |

## Verification
The bench builds the decoder with its default prefix codes, 0xDD, 0xFD, 0xCB and 0xED. With these codes every opcode value can be swept in each form: unprefixed, under both index prefixes, and in both indexed bit/shift forms. The expected memory-operand, half-register and write-back flags come from field arithmetic on each opcode. Directed sequences add prefix chains, extended-table cancellation, and idle cycles in the middle of an instruction, so the hold and no-completion rules can be seen at the ports.

// File: rtl/idx_prefix_pkg.sv
package idx_prefix_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PTR_HL = 2'd0,
    PTR_IX = 2'd1,
    PTR_IY = 2'd2
  } ptr_e;

  typedef enum logic [1:0] {
    TBL_MAIN = 2'd0,
    TBL_BIT  = 2'd1,
    TBL_EXT  = 2'd2
  } tbl_e;

  typedef enum logic [2:0] {
    PUB_NONE,
    PUB_MAIN,    // opcode taken from the current byte, main table
    PUB_IDXMEM,  // held opcode, current byte is the displacement
    PUB_IDXBIT,  // indexed bit/shift, held displacement, current opcode
    PUB_BIT,     // plain bit/shift table
    PUB_EXT      // extended table
  } pub_e;

  typedef struct packed {
    logic setIdx;   // current byte is an index prefix
    logic clrIdx;   // drop a pending index prefix
    logic holdOp;   // capture current byte as the pending opcode
    logic holdDisp; // capture current byte as the displacement
    pub_e pub;      // publish a decoded instruction this cycle
  } ctl_s;

endpackage

// File: rtl/idx_prefix_ctrl.sv
module idx_prefix_ctrl
  import idx_prefix_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IX_PREFIX  = 8'hDD,
  parameter logic [BYTE_W-1:0] IY_PREFIX  = 8'hFD,
  parameter logic [BYTE_W-1:0] BIT_PREFIX = 8'hCB,
  parameter logic [BYTE_W-1:0] EXT_PREFIX = 8'hED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              needsDisp,
  output ctl_s              ctl,
  output logic              instrDone
);

  typedef enum logic [2:0] {
    ST_BASE,
    ST_IDX,
    ST_BIT,
    ST_EXT,
    ST_IDXMEM,
    ST_IDXBITD,
    ST_IDXBITOP
  } state_e;

  state_e state, stateNext;

  logic isIdx, isBit, isExt;
  assign isIdx = (byteIn == IX_PREFIX) || (byteIn == IY_PREFIX);
  assign isBit = (byteIn == BIT_PREFIX);
  assign isExt = (byteIn == EXT_PREFIX);

  always_comb begin
    stateNext    = state;
    ctl.setIdx   = 1'b0;
    ctl.clrIdx   = 1'b0;
    ctl.holdOp   = 1'b0;
    ctl.holdDisp = 1'b0;
    ctl.pub      = PUB_NONE;
    if (byteValid) begin
      unique case (state)
        ST_BASE: begin
          if (isIdx) begin
            ctl.setIdx = 1'b1;
            stateNext  = ST_IDX;
          end else if (isBit) begin
            stateNext = ST_BIT;
          end else if (isExt) begin
            stateNext = ST_EXT;
          end else begin
            ctl.pub = PUB_MAIN;
          end
        end
        ST_IDX: begin
          if (isIdx) begin
            ctl.setIdx = 1'b1;
          end else if (isExt) begin
            ctl.clrIdx = 1'b1;
            stateNext  = ST_EXT;
          end else if (isBit) begin
            stateNext = ST_IDXBITD;
          end else if (needsDisp) begin
            ctl.holdOp = 1'b1;
            stateNext  = ST_IDXMEM;
          end else begin
            ctl.pub   = PUB_MAIN;
            stateNext = ST_BASE;
          end
        end
        ST_IDXMEM: begin
          ctl.pub   = PUB_IDXMEM;
          stateNext = ST_BASE;
        end
        ST_IDXBITD: begin
          ctl.holdDisp = 1'b1;
          stateNext    = ST_IDXBITOP;
        end
        ST_IDXBITOP: begin
          ctl.pub   = PUB_IDXBIT;
          stateNext = ST_BASE;
        end
        ST_BIT: begin
          ctl.pub   = PUB_BIT;
          stateNext = ST_BASE;
        end
        ST_EXT: begin
          ctl.pub   = PUB_EXT;
          stateNext = ST_BASE;
        end
        default: stateNext = ST_BASE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BASE;
      instrDone <= 1'b0;
    end else begin
      state     <= stateNext;
      instrDone <= (ctl.pub != PUB_NONE);
    end
  end

  // R10: a completion always follows an accepted byte
  p_done_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    instrDone |-> $past(byteValid));

  // R10: an idle cycle leaves the sequencer where it was
  p_idle_holds_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> $stable(state));

  // R7: the bit/shift opcode can only come after the displacement was captured
  p_bitop_after_disp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDXBITOP) |-> $past(state == ST_IDXBITOP || state == ST_IDXBITD));

endmodule

// File: rtl/idx_prefix_dpath.sv
module idx_prefix_dpath
  import idx_prefix_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IX_PREFIX = 8'hDD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byteIn,
  input  ctl_s              ctl,
  output logic              needsDisp,
  output logic [BYTE_W-1:0] opcode,
  output ptr_e              ptrSel,
  output tbl_e              tableSel,
  output logic              useHi,
  output logic              useLo,
  output logic              dispValid,
  output logic [BYTE_W-1:0] disp,
  output logic              copyToReg
);

  localparam logic [2:0] FLD_H   = 3'd4;
  localparam logic [2:0] FLD_L   = 3'd5;
  localparam logic [2:0] FLD_MEM = 3'd6;

  // opcode fields: group in [7:6], destination in [5:3], source in [2:0]
  function automatic logic memOperand(input logic [BYTE_W-1:0] op);
    unique case (op[7:6])
      2'd0:    memOperand = (op == 8'h34) || (op == 8'h35) || (op == 8'h36);
      2'd1:    memOperand = (op != 8'h76) && ((op[5:3] == FLD_MEM) || (op[2:0] == FLD_MEM));
      2'd2:    memOperand = (op[2:0] == FLD_MEM);
      default: memOperand = 1'b0;
    endcase
  endfunction

  function automatic logic namesReg(input logic [BYTE_W-1:0] op, input logic [2:0] fld);
    unique case (op[7:6])
      2'd0:    namesReg = (op[5:3] == fld) && (op[2:0] >= 3'd4) && (op[2:0] <= 3'd6);
      2'd1:    namesReg = (op[5:3] == fld) || (op[2:0] == fld);
      2'd2:    namesReg = (op[2:0] == fld);
      default: namesReg = 1'b0;
    endcase
  endfunction

  function automatic logic isExchange(input logic [BYTE_W-1:0] op);
    isExchange = (op == 8'hEB) || (op == 8'hD9);
  endfunction

  ptr_e              idxReg;
  logic [BYTE_W-1:0] heldOp;
  logic [BYTE_W-1:0] heldDisp;
  logic              idxActive;
  logic              exchHere;

  assign needsDisp = memOperand(byteIn);
  assign idxActive = (idxReg != PTR_HL);
  assign exchHere  = isExchange(byteIn);

  // pending prefix and captured bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxReg   <= PTR_HL;
      heldOp   <= '0;
      heldDisp <= '0;
    end else begin
      if (ctl.setIdx)
        idxReg <= (byteIn == IX_PREFIX) ? PTR_IX : PTR_IY;
      else if (ctl.clrIdx || (ctl.pub != PUB_NONE))
        idxReg <= PTR_HL;
      if (ctl.holdOp)
        heldOp <= byteIn;
      if (ctl.holdDisp)
        heldDisp <= byteIn;
    end
  end

  // published instruction report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode    <= '0;
      ptrSel    <= PTR_HL;
      tableSel  <= TBL_MAIN;
      useHi     <= 1'b0;
      useLo     <= 1'b0;
      dispValid <= 1'b0;
      disp      <= '0;
      copyToReg <= 1'b0;
    end else if (ctl.pub != PUB_NONE) begin
      opcode    <= byteIn;
      ptrSel    <= PTR_HL;
      tableSel  <= TBL_MAIN;
      useHi     <= 1'b0;
      useLo     <= 1'b0;
      dispValid <= 1'b0;
      disp      <= '0;
      copyToReg <= 1'b0;
      unique case (ctl.pub)
        PUB_MAIN: begin
          if (idxActive && !exchHere) begin
            ptrSel <= idxReg;
            useHi  <= namesReg(byteIn, FLD_H);
            useLo  <= namesReg(byteIn, FLD_L);
          end
        end
        PUB_IDXMEM: begin
          opcode    <= heldOp;
          ptrSel    <= idxReg;
          dispValid <= 1'b1;
          disp      <= byteIn;
        end
        PUB_IDXBIT: begin
          ptrSel    <= idxReg;
          tableSel  <= TBL_BIT;
          dispValid <= 1'b1;
          disp      <= heldDisp;
          copyToReg <= (byteIn[2:0] != FLD_MEM);
        end
        PUB_BIT: tableSel <= TBL_BIT;
        PUB_EXT: tableSel <= TBL_EXT;
        default: ;
      endcase
    end
  end

  // R6: a displacement-completed instruction always has an index pending
  p_mem_has_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pub == PUB_IDXMEM) |-> idxActive);

  // R7: the indexed bit/shift form also has an index pending
  p_bit_has_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pub == PUB_IDXBIT) |-> idxActive);

  // R4: after any completion no index prefix is left over
  p_index_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pub != PUB_NONE) |=> (idxReg == PTR_HL));

endmodule

// File: rtl/idx_prefix_decoder.sv
module idx_prefix_decoder
  import idx_prefix_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IX_PREFIX  = 8'hDD,
  parameter logic [BYTE_W-1:0] IY_PREFIX  = 8'hFD,
  parameter logic [BYTE_W-1:0] BIT_PREFIX = 8'hCB,
  parameter logic [BYTE_W-1:0] EXT_PREFIX = 8'hED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              instrDone,
  output logic [BYTE_W-1:0] opcode,
  output logic [1:0]        ptrSel,
  output logic [1:0]        tableSel,
  output logic              useHi,
  output logic              useLo,
  output logic              dispValid,
  output logic [BYTE_W-1:0] disp,
  output logic              copyToReg
);

  ctl_s ctl;
  logic needsDisp;
  ptr_e ptrInt;
  tbl_e tblInt;

  idx_prefix_ctrl #(
    .IX_PREFIX (IX_PREFIX),
    .IY_PREFIX (IY_PREFIX),
    .BIT_PREFIX(BIT_PREFIX),
    .EXT_PREFIX(EXT_PREFIX)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .byteValid(byteValid),
    .byteIn   (byteIn),
    .needsDisp(needsDisp),
    .ctl      (ctl),
    .instrDone(instrDone)
  );

  idx_prefix_dpath #(
    .IX_PREFIX(IX_PREFIX)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .byteIn   (byteIn),
    .ctl      (ctl),
    .needsDisp(needsDisp),
    .opcode   (opcode),
    .ptrSel   (ptrInt),
    .tableSel (tblInt),
    .useHi    (useHi),
    .useLo    (useLo),
    .dispValid(dispValid),
    .disp     (disp),
    .copyToReg(copyToReg)
  );

  assign ptrSel   = ptrInt;
  assign tableSel = tblInt;

  // R5/R6: half-register flags never come with a displacement and need an index
  p_halves_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    instrDone && (useHi || useLo) |-> !dispValid && (ptrSel != 2'd0));

  // R8: write-back only in the indexed bit/shift form
  p_copy_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
    instrDone && copyToReg |-> (tableSel == 2'd1) && dispValid);

  // R12: report is held between completions
  p_report_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !instrDone |-> $stable(opcode) && $stable(ptrSel) && $stable(disp));

endmodule

// File: tb/idx_prefix_decoder_test.sv
module idx_prefix_decoder_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       instrDone;
  logic [7:0] opcode;
  logic [1:0] ptrSel;
  logic [1:0] tableSel;
  logic       useHi, useLo, dispValid, copyToReg;
  logic [7:0] disp;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_prefix_decoder uut (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteIn(byteIn),
    .instrDone(instrDone), .opcode(opcode), .ptrSel(ptrSel), .tableSel(tableSel),
    .useHi(useHi), .useLo(useLo), .dispValid(dispValid), .disp(disp),
    .copyToReg(copyToReg)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteIn = b;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic report(input string req, input logic [7:0] op, input logic [1:0] ptr,
                        input logic [1:0] tbl, input logic hi, input logic lo,
                        input logic dv, input logic [7:0] d, input logic cp);
    chk(req, "done",  {31'b0, instrDone}, 32'd1);
    chk(req, "opcode", {24'b0, opcode}, {24'b0, op});
    chk(req, "ptr",   {30'b0, ptrSel}, {30'b0, ptr});
    chk(req, "table", {30'b0, tableSel}, {30'b0, tbl});
    chk(req, "flags", {27'b0, useHi, useLo, dispValid, copyToReg, 1'b0},
                      {27'b0, hi, lo, dv, cp, 1'b0});
    if (dv) chk(req, "disp", {24'b0, disp}, {24'b0, d});
  endtask

  function automatic bit isPrefix(input logic [7:0] b);
    return (b == 8'hDD) || (b == 8'hFD) || (b == 8'hCB) || (b == 8'hED);
  endfunction

  // expected classification, written from the requirement text
  function automatic bit expMem(input logic [7:0] b);
    if (b >= 8'h34 && b <= 8'h36) return 1'b1;
    if (b >= 8'h40 && b <= 8'h7F) return (b != 8'h76) && ((b / 8) % 8 == 6 || b % 8 == 6);
    if (b >= 8'h80 && b <= 8'hBF) return (b % 8 == 6);
    return 1'b0;
  endfunction

  function automatic bit expNames(input logic [7:0] b, input int v);
    if (v == 4 && b >= 8'h24 && b <= 8'h26) return 1'b1;
    if (v == 5 && b >= 8'h2C && b <= 8'h2E) return 1'b1;
    if (b >= 8'h40 && b <= 8'h7F) return ((b / 8) % 8 == v) || (b % 8 == v);
    if (b >= 8'h80 && b <= 8'hBF) return (b % 8 == v);
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done", {31'b0, instrDone}, 32'd0);
    chk("R1", "report", {opcode, disp, 4'b0, ptrSel, tableSel, useHi, useLo, dispValid, copyToReg}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after release", {31'b0, instrDone}, 32'd0);

    // R2: every non-prefix byte unprefixed
    for (int op = 0; op < 256; op++) begin
      if (!isPrefix(8'(op))) begin
        sendByte(8'(op));
        report("R2", 8'(op), 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
      end
    end

    // R3/R5/R6/R9: every main opcode under both index prefixes
    for (int p = 0; p < 2; p++) begin
      for (int op = 0; op < 256; op++) begin
        logic [7:0] b;
        logic [1:0] ix;
        b  = 8'(op);
        ix = (p == 0) ? 2'd1 : 2'd2;
        if (!isPrefix(b)) begin
          sendByte(p == 0 ? 8'hDD : 8'hFD);
          chk("R3", "no done on prefix", {31'b0, instrDone}, 32'd0);
          sendByte(b);
          if (expMem(b)) begin
            chk("R6", "no done before disp", {31'b0, instrDone}, 32'd0);
            sendByte(b ^ 8'hA5);
            report("R6", b, ix, 2'd0, 1'b0, 1'b0, 1'b1, b ^ 8'hA5, 1'b0);
          end else if (b == 8'hEB || b == 8'hD9) begin
            report("R9", b, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
          end else begin
            report("R5", b, ix, 2'd0, expNames(b, 4), expNames(b, 5), 1'b0, 8'h00, 1'b0);
          end
        end
      end
    end

    // R7/R8: indexed bit/shift form, all opcodes, both prefixes
    for (int p = 0; p < 2; p++) begin
      for (int op = 0; op < 256; op++) begin
        logic [7:0] d;
        d = 8'(op * 7 + 3);
        sendByte(p == 0 ? 8'hDD : 8'hFD);
        sendByte(8'hCB);
        chk("R7", "no done after CB", {31'b0, instrDone}, 32'd0);
        sendByte(d);
        chk("R7", "no done after disp", {31'b0, instrDone}, 32'd0);
        sendByte(8'(op));
        report("R8", 8'(op), (p == 0) ? 2'd1 : 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, d, (op % 8) != 6);
      end
    end

    // R11: plain bit/shift and extended tables, including a prefix-valued final byte
    for (int op = 0; op < 256; op += 17) begin
      sendByte(8'hCB);
      sendByte(8'(op));
      report("R11", 8'(op), 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
      sendByte(8'hED);
      sendByte(8'(op));
      report("R11", 8'(op), 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    end

    // R4: chains
    sendByte(8'hDD); sendByte(8'hFD); sendByte(8'h21);
    report("R4", 8'h21, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    sendByte(8'hFD); sendByte(8'hDD); sendByte(8'hDD); sendByte(8'h65);
    report("R4", 8'h65, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    sendByte(8'hDD); sendByte(8'hED); sendByte(8'h4A);
    report("R4", 8'h4A, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    sendByte(8'hFD); sendByte(8'hDD); sendByte(8'hCB); sendByte(8'h80); sendByte(8'h46);
    report("R4", 8'h46, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 8'h80, 1'b0);

    // R10/R12: idle cycles inside an instruction, and one-cycle strobe
    sendByte(8'h3C);
    @(negedge clk);
    chk("R12", "strobe one cycle", {31'b0, instrDone}, 32'd0);
    chk("R12", "opcode held", {24'b0, opcode}, 32'h3C);
    sendByte(8'hFD);
    repeat (4) @(negedge clk);
    chk("R10", "no done while idle", {31'b0, instrDone}, 32'd0);
    chk("R12", "opcode held idle", {24'b0, opcode}, 32'h3C);
    sendByte(8'h7C);
    report("R10", 8'h7C, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    sendByte(8'hDD); sendByte(8'h66);
    repeat (3) @(negedge clk);
    chk("R10", "waiting for disp", {31'b0, instrDone}, 32'd0);
    sendByte(8'hFE);
    report("R10", 8'h66, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 8'hFE, 1'b0);
    sendByte(8'hDD); sendByte(8'hCB);
    repeat (2) @(negedge clk);
    sendByte(8'h10);
    repeat (2) @(negedge clk);
    chk("R10", "waiting for bit op", {31'b0, instrDone}, 32'd0);
    sendByte(8'h06);
    report("R10", 8'h06, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 8'h10, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule